// File: doc/BRIEF.md
# Prefix-Timed Upper-Bank Override

This block lets an 8-bit processor with a 64 KB address space reach a second 64 KB bank for exactly one data access. It observes the opcode-fetch strobe and the data bus. When the processor fetches a chosen one-cycle no-operation opcode, the block treats that fetch as a prefix and starts a short delay line. When the delay line expires, the block drives the extra address line, the seventeenth bit, high. The data cycles of the instruction that follows the prefix then go to the upper bank. The override clears itself at the next opcode fetch, so it needs no bank register and no write to undo.

The delay comes from a parameter between 2 and 4 cycles. Each use of the prefix must be matched to the timing of the instruction that follows it. Instruction fetches always come from the lower bank. This is because the extra address line is held low in every cycle where the fetch strobe is high. A busy output shows whether an override is counting down or active.

Top module: `bank_override_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle. After that edge, `a16` and `busy` are both 0.
- R2: A prefix is recognised only when `sync` is 1 and `data_in` equals `PREFIX_OPCODE` (default 8'h03) at a rising edge. The same byte seen with `sync` at 0 has no effect on `a16` or `busy`.
- R3: Suppose a prefix is sampled at edge k. With `DELAY` (2 to 4, default 3), `a16` is 1 in the cycle after edge k+DELAY, provided `sync` is 0 in that cycle.
- R4: Once asserted, the override stays in force through every following cycle with `sync` at 0. It clears at the first rising edge where `sync` is sampled 1.
- R5: `a16` is 0 in every cycle in which `sync` is 1, so opcode fetches always use the lower bank.
- R6: If no prefix has been seen since reset, or since the last override cleared, `a16` stays 0 and both code and data use the lower bank.
- R7: A new prefix that arrives while a countdown is pending restarts the count from that prefix.
- R8: `busy` is 1 from the edge that samples a prefix until the edge where the resulting override clears. Outside that span it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | High during an opcode-fetch cycle |
| data_in | input | 8 | Processor data bus, compared against the prefix opcode |
| a16 | output | 1 | Seventeenth address bit; 1 selects the upper 64 KB bank |
| busy | output | 1 | Countdown pending or override active |

## Verification
A reference model built on edge timestamps is compared with both outputs on every cycle. Directed runs cover these cases:
- A plain stream of opcodes containing no prefix. This separates correct idle behaviour from spurious bank selection.
- The prefix byte appearing as data with `sync` low. This tells a real prefix apart from an operand byte.
- A lone prefix followed by several data cycles. This confirms the exact rise cycle and that the override holds until the next fetch.
- Two prefixes close together. This tells a restarted countdown apart from one that keeps the first timing.
- A fetch landing in the very cycle the override would assert. This exposes any leak of the upper bank into an opcode fetch.

A reset in the middle of an override and a long random stream follow these directed runs.

// File: rtl/bov_pkg.sv
// Package: shared constants and types for the bank override sequencer.
// Assumes an 8-bit data bus and a delay line no longer than MAX_DELAY taps.
package bov_pkg;
    localparam int unsigned MAX_DELAY      = 4;
    localparam int unsigned MIN_DELAY      = 2;
    typedef logic [7:0] opcode_t;
    localparam opcode_t     DEFAULT_PREFIX = 8'h03;
endpackage

// File: rtl/bov_prefix_detect.sv
// Module: recognises the prefix opcode during an opcode-fetch cycle.
// Assumes data_in is valid whenever sync is high at the sampling edge.
module bov_prefix_detect
    import bov_pkg::*;
#(
    parameter opcode_t PREFIX_OPCODE = DEFAULT_PREFIX
) (
    input  logic    sync,
    input  opcode_t data_in,
    output logic    hit
);
    // Purpose: flag a fetch whose opcode is the prefix.
    always_comb begin
        hit = sync && (data_in == PREFIX_OPCODE);
    end
endmodule

// File: rtl/bov_delay_line.sv
// Module: one-hot token shift register timing the override.
// A load injects a token at bit 0. The token moves up one bit per cycle and
// vanishes after the tap at bit DELAY-1. Bits at and above DELAY stay zero.
// Assumes MIN_DELAY <= DELAY <= LEN-1.
module bov_delay_line #(
    parameter int unsigned DELAY = 3,
    parameter int unsigned LEN   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic tap,
    output logic pending
);
    logic [LEN-1:0] sr_q;
    logic [LEN-1:0] sr_d;

    // Purpose: next-state of each stage; a load flushes older tokens.
    for (genvar i = 0; i < LEN; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign sr_d[i] = load;
        end else if (i < DELAY) begin : g_mid
            assign sr_d[i] = !load && sr_q[i-1];
        end else begin : g_unused
            assign sr_d[i] = 1'b0;
        end
    end

    // Purpose: register the token chain with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign tap     = sr_q[DELAY-1];
    assign pending = |sr_q;
endmodule

// File: rtl/bov_override_hold.sv
// Module: holds the bank override from tap expiry until the next opcode fetch.
// An expiring tap has priority over a clearing fetch in the same cycle.
module bov_override_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic sync,
    output logic armed
);
    // Purpose: set on tap expiry, clear on a sampled opcode fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)    armed <= 1'b0;
        else if (fire) armed <= 1'b1;
        else if (sync) armed <= 1'b0;
    end
endmodule

// File: rtl/bank_override_seq.sv
// Module: top of the prefix-timed bank override sequencer.
// Drives the seventeenth address bit high for the data cycles of the
// instruction after a prefix, and holds it low in every fetch cycle.
// Assumes sync marks opcode fetches and that the prefix takes one cycle.
module bank_override_seq
    import bov_pkg::*;
#(
    parameter int unsigned DELAY         = 3,
    parameter opcode_t     PREFIX_OPCODE = DEFAULT_PREFIX
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync,
    input  logic [7:0] data_in,
    output logic       a16,
    output logic       busy
);
    localparam int unsigned LEN = MAX_DELAY + 1;

    logic prefix_hit;
    logic tap;
    logic pending;
    logic armed;

    bov_prefix_detect #(.PREFIX_OPCODE(PREFIX_OPCODE)) u_detect (
        .sync    (sync),
        .data_in (data_in),
        .hit     (prefix_hit)
    );

    bov_delay_line #(.DELAY(DELAY), .LEN(LEN)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (prefix_hit),
        .tap     (tap),
        .pending (pending)
    );

    bov_override_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (tap),
        .sync  (sync),
        .armed (armed)
    );

    // Purpose: gate the override off during fetches; report activity.
    always_comb begin
        a16  = armed && !sync;
        busy = pending || armed;
    end
endmodule

// File: rtl/bank_override_seq_chk.sv
// Checker: temporal properties of the bank override sequencer, bound to the top.
module bank_override_seq_chk #(
    parameter logic [7:0] PREFIX_OPCODE = 8'h03
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sync,
    input logic [7:0] data_in,
    input logic       a16,
    input logic       busy
);
    // R1: the cycle after a reset edge is idle
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!a16 && !busy));

    // R5: no upper-bank fetch
    p_fetch_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> !a16);

    // R6: an idle block never selects the upper bank
    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !a16);

    // R8: a sampled prefix makes the block busy
    p_prefix_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && data_in == PREFIX_OPCODE) |=> busy);

    // R2: the prefix byte as data leaves an idle block idle
    p_ignore_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sync && data_in == PREFIX_OPCODE) |=> !busy);

    // R4: an active override persists until a fetch
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        a16 |=> (sync || a16));
endmodule

bind bank_override_seq bank_override_seq_chk #(.PREFIX_OPCODE(PREFIX_OPCODE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync    (sync),
    .data_in (data_in),
    .a16     (a16),
    .busy    (busy)
);

// File: tb/bank_override_seq_test.sv
module bank_override_seq_test;
    localparam int unsigned DELAY  = 3;
    localparam logic [7:0]  PREFIX = 8'h03;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       a16;
    logic       busy;

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1";
    bit    done     = 1'b0;

    // reference model state
    longint edge_n   = 0;
    longint fire_at  = -1;
    bit     m_armed  = 1'b0;
    bit     m_pend   = 1'b0;

    bank_override_seq #(.DELAY(DELAY), .PREFIX_OPCODE(PREFIX)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync    (sync),
        .data_in (data_in),
        .a16     (a16),
        .busy    (busy)
    );

    always #2 clk = ~clk;

    // Reference model: timestamp of override start, updated per edge.
    always @(posedge clk) begin
        edge_n = edge_n + 1;
        if (!rst_n) begin
            m_armed = 1'b0;
            fire_at = -1;
        end else begin
            if (fire_at == edge_n)        m_armed = 1'b1;
            else if (sync && m_armed)     m_armed = 1'b0;
            if (sync && data_in == PREFIX) fire_at = edge_n + DELAY;
        end
        m_pend = (fire_at > edge_n);
    end

    // Compare 1 ns after each rising edge, while inputs are stable.
    always @(posedge clk) begin
        #1;
        begin
            bit exp_a16;
            bit exp_busy;
            exp_a16  = m_armed && !sync;
            exp_busy = m_pend || m_armed;
            n_checks++;
            if (a16 !== exp_a16) begin
                n_fail++;
                $display("FAIL %s: a16 actual=%b expected=%b at edge %0d", phase, a16, exp_a16, edge_n);
            end
            n_checks++;
            if (busy !== exp_busy) begin
                n_fail++;
                $display("FAIL %s: busy actual=%b expected=%b at edge %0d", phase, busy, exp_busy, edge_n);
            end
        end
    end

    task automatic cyc(input bit s, input logic [7:0] d);
        @(negedge clk);
        sync    = s;
        data_in = d;
    endtask

    task automatic data_cycles(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'hA5);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        repeat (3) cyc(1'b0, 8'h00);
        cyc(1'b1, PREFIX);
        rst_n = 1'b0;
        repeat (2) cyc(1'b0, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R6: ordinary instruction stream without a prefix
        phase = "R6";
        for (int i = 0; i < 20; i++) cyc(i % 3 == 0, 8'h10 + 8'(i));

        // R2: prefix byte seen as operand data
        phase = "R2";
        for (int i = 0; i < 6; i++) cyc(1'b0, PREFIX);
        cyc(1'b1, 8'hEA);
        data_cycles(3);

        // R3/R4: lone prefix, next fetch, long data phase, then fetch
        phase = "R3_R4";
        cyc(1'b1, PREFIX);
        cyc(1'b1, 8'hAD);
        data_cycles(6);
        cyc(1'b1, 8'hEA);
        data_cycles(3);

        // R7: second prefix restarts the count
        phase = "R7";
        cyc(1'b1, PREFIX);
        cyc(1'b0, 8'h00);
        cyc(1'b1, PREFIX);
        cyc(1'b1, 8'hB1);
        data_cycles(5);
        cyc(1'b1, 8'hEA);
        data_cycles(2);

        // R5: fetch lands exactly when the override would start
        phase = "R5";
        cyc(1'b1, PREFIX);
        data_cycles(DELAY - 1);
        cyc(1'b1, 8'h8D);
        data_cycles(3);
        cyc(1'b1, 8'hEA);

        // R8: busy spans prefix to release, back-to-back prefixes
        phase = "R8";
        cyc(1'b1, PREFIX);
        cyc(1'b1, PREFIX);
        cyc(1'b1, PREFIX);
        data_cycles(6);
        cyc(1'b1, 8'hEA);

        // R1: reset while override is active
        phase = "R1";
        cyc(1'b1, PREFIX);
        data_cycles(DELAY + 1);
        rst_n = 1'b0;
        cyc(1'b0, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        data_cycles(4);

        // Mixed random stream covering all requirements
        phase = "R2_R3_R4_R5_R7_R8";
        for (int i = 0; i < 3000; i++) begin
            bit s;
            logic [7:0] d;
            s = ($urandom % 3) == 0;
            d = (($urandom % 4) == 0) ? PREFIX : 8'($urandom);
            cyc(s, d);
        end
        cyc(1'b0, 8'h00);
        @(negedge clk);
        finish_run();
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule